// File: doc/BRIEF.md
# Tree-structured dual-rail lookahead adder

This block adds two unsigned operands that arrive in dual-rail form and returns a dual-rail sum and carry-out. Each operand bit is first classified as kill, generate or propagate using a one-hot code. A binary tree then merges neighbouring spans into group classes, one tree level per clock cycle. Carries are resolved per bit position as soon as enough information exists, so the completion time depends on the data rather than on a fixed tree depth.

A resolved group kill or generate at the root of a left subtree is applied at once to every node along the left edge of the neighbouring right subtree. All of these nodes share the same lowest bit, so one register per bit position holds their common carry-in. A propagating bit can also pass a known carry one position upward. Operands with short carry chains therefore finish well before the tree bound.

The handshake follows return-to-zero practice. The operands are presented and the block waits for `done`. The operands must then return to all-spacer, which clears every result before the next pair is accepted. The width is a power-of-two parameter.

Top module: `dicla_tree_adder`

## Requirements
- R1: Operand, sum and carry-out bits use the dual-rail code 00 = no data, 01 = logic 0, 10 = logic 1. Once `done` is high, the sum equals (A+B) mod 2^WIDTH, bit i at `sum_dr[2i+1:2i]`.
- R2: A bit position is classified kill when both operand bits are 0, generate when both are 1, and propagate otherwise. The class is held one-hot: 000 none, 001 kill, 010 generate, 100 propagate.
- R3: A group over two adjacent spans takes the upper span's class when that class is kill or generate. Otherwise it takes the lower span's class. A span resolves only once both halves are resolved.
- R4: The carry into bit j (carry into bit WIDTH is the carry-out) resolves to 0 or 1 in any of these cases: bit j-1 kills or generates; the span just below j that is aligned to the lowest set bit of j kills or generates; that span propagates and the carry at its base is known; bit j-1 propagates and the carry into j-1 is known. The carry into bit 0 is 0.
- R5: `done` is high exactly when all sum bits and the carry-out hold valid values. It is reached no more than 2*log2(WIDTH)+2 rising edges after a complete valid operand pair is applied.
- R6: When every bit position kills or generates (A equal to B), `done` is high after exactly 3 rising edges.
- R7: When every operand bit is 00, the sum, the carry-out and `done` return to spacer and low on the next rising edge.
- R8: Once a result is valid, changing operands to other valid values without passing through spacer has no effect on sum, carry-out or `done`.
- R9: Any operand bit at 11 sets `err` on the next edge. No evaluation starts while any bit is 11 or 00. Evaluation starts once every bit becomes valid.
- R10: Synchronous active-high `rst` clears the sum and carry-out to 00 and drives `done` and `err` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| a_dr | input | 2*WIDTH | Operand A, dual-rail, two wires per bit |
| b_dr | input | 2*WIDTH | Operand B, dual-rail, two wires per bit |
| sum_dr | output | 2*WIDTH | Sum, dual-rail |
| cout_dr | output | 2 | Carry-out, dual-rail |
| done | output | 1 | All result bits valid |
| err | output | 1 | An illegal 11 code was seen on the previous edge |

## Verification
On every cycle, the assertions check the following: class codes stay one-hot; a group class agrees with its children; carries never take the illegal code; resolved carries and sums never change until a spacer arrives; spacer input clears `done`; a bad code cannot start evaluation; a busy counter stays under the tree latency bound. Only the bench scenarios show that the arithmetic is correct for every operand pair, that equal operands finish in three edges, and that operands changed without a spacer leave the held result untouched.

// File: rtl/dicla_pkg.sv
package dicla_pkg;

    typedef enum logic [2:0] {
        KGP_NONE = 3'b000,
        KGP_KILL = 3'b001,
        KGP_GEN  = 3'b010,
        KGP_PROP = 3'b100
    } kgp_e;

    typedef logic [1:0] dr_t;

    localparam dr_t DR_NULL = 2'b00;
    localparam dr_t DR_ZERO = 2'b01;
    localparam dr_t DR_ONE  = 2'b10;
    localparam dr_t DR_BAD  = 2'b11;

    function automatic logic dr_ok(dr_t v);
        return (v == DR_ZERO) || (v == DR_ONE);
    endfunction

    function automatic dr_t dr_of(logic b);
        return b ? DR_ONE : DR_ZERO;
    endfunction

    // classify one bit position from two valid dual-rail operand bits
    function automatic kgp_e leaf_class(dr_t a, dr_t b);
        if (a == DR_ZERO && b == DR_ZERO) return KGP_KILL;
        if (a == DR_ONE && b == DR_ONE)   return KGP_GEN;
        return KGP_PROP;
    endfunction

    // upper span decides unless it propagates
    function automatic kgp_e merge_kgp(kgp_e hi, kgp_e lo);
        if (hi != KGP_PROP) return hi;
        return lo;
    endfunction

    function automatic dr_t kgp_to_carry(kgp_e k);
        case (k)
            KGP_KILL: return DR_ZERO;
            KGP_GEN:  return DR_ONE;
            default:  return DR_NULL;
        endcase
    endfunction

    function automatic int lowbit(int j);
        return j & (-j);
    endfunction

    function automatic int log2i(int v);
        int r;
        r = 0;
        while ((1 << r) < v) r++;
        return r;
    endfunction

endpackage

// File: rtl/dicla_leaf.sv
module dicla_leaf
    import dicla_pkg::*;
(
    input  logic clk,
    input  logic clear,
    input  logic load,
    input  dr_t  a_i,
    input  dr_t  b_i,
    output kgp_e kgp_o
);
    kgp_e kgp_q;

    always_ff @(posedge clk) begin
        if (clear)
            kgp_q <= KGP_NONE;
        else if (load && kgp_q == KGP_NONE)
            kgp_q <= leaf_class(a_i, b_i);
    end

    assign kgp_o = kgp_q;

    p_leaf_onehot_r2: assert property (@(posedge clk) disable iff (clear)
        $onehot0(kgp_q));

endmodule

// File: rtl/dicla_node.sv
module dicla_node
    import dicla_pkg::*;
(
    input  logic clk,
    input  logic clear,
    input  kgp_e hi_i,
    input  kgp_e lo_i,
    output kgp_e grp_o
);
    kgp_e grp_q;

    always_ff @(posedge clk) begin
        if (clear)
            grp_q <= KGP_NONE;
        else if (grp_q == KGP_NONE && hi_i != KGP_NONE && lo_i != KGP_NONE)
            grp_q <= merge_kgp(hi_i, lo_i);
    end

    assign grp_o = grp_q;

    // a resolved group propagates only when both halves propagate
    p_group_consistent_r3: assert property (@(posedge clk) disable iff (clear)
        (grp_q != KGP_NONE) |->
            (hi_i != KGP_NONE && lo_i != KGP_NONE &&
             ((grp_q == KGP_PROP) == (hi_i == KGP_PROP && lo_i == KGP_PROP))));

endmodule

// File: rtl/dicla_carry.sv
module dicla_carry
    import dicla_pkg::*;
(
    input  logic clk,
    input  logic clear,
    input  kgp_e prev_i,     // class of the bit just below
    input  dr_t  prev_c_i,   // carry into the bit just below
    input  kgp_e sib_i,      // class of the aligned span just below
    input  dr_t  base_c_i,   // carry into the base of that span
    output dr_t  c_o
);
    dr_t c_q;
    dr_t c_d;

    always_comb begin
        if (prev_i == KGP_KILL || prev_i == KGP_GEN)
            c_d = kgp_to_carry(prev_i);
        else if (sib_i == KGP_KILL || sib_i == KGP_GEN)
            c_d = kgp_to_carry(sib_i);
        else if (sib_i == KGP_PROP && dr_ok(base_c_i))
            c_d = base_c_i;
        else if (prev_i == KGP_PROP && dr_ok(prev_c_i))
            c_d = prev_c_i;
        else
            c_d = DR_NULL;
    end

    always_ff @(posedge clk) begin
        if (clear)
            c_q <= DR_NULL;
        else if (c_q == DR_NULL)
            c_q <= c_d;
    end

    assign c_o = c_q;

    p_carry_legal_r1: assert property (@(posedge clk) disable iff (clear)
        c_q != DR_BAD);

    p_carry_hold_r8: assert property (@(posedge clk) disable iff (clear)
        dr_ok(c_q) |=> c_q == $past(c_q));

    p_carry_gen_r4: assert property (@(posedge clk) disable iff (clear)
        (prev_i == KGP_GEN && c_q == DR_NULL) |=> c_q == DR_ONE);

endmodule

// File: rtl/dicla_sum.sv
module dicla_sum
    import dicla_pkg::*;
(
    input  logic clk,
    input  logic clear,
    input  kgp_e bit_i,
    input  dr_t  c_i,
    output dr_t  s_o
);
    dr_t s_q;

    always_ff @(posedge clk) begin
        if (clear)
            s_q <= DR_NULL;
        else if (s_q == DR_NULL && bit_i != KGP_NONE && dr_ok(c_i))
            s_q <= dr_of((bit_i == KGP_PROP) ^ (c_i == DR_ONE));
    end

    assign s_o = s_q;

    p_sum_needs_carry_r5: assert property (@(posedge clk) disable iff (clear)
        dr_ok(s_q) |-> dr_ok(c_i));

    p_sum_hold_r8: assert property (@(posedge clk) disable iff (clear)
        dr_ok(s_q) |=> s_q == $past(s_q));

endmodule

// File: rtl/dicla_tree_adder.sv
module dicla_tree_adder
    import dicla_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [2*WIDTH-1:0] a_dr,
    input  logic [2*WIDTH-1:0] b_dr,
    output logic [2*WIDTH-1:0] sum_dr,
    output logic [1:0]         cout_dr,
    output logic               done,
    output logic               err
);
    localparam int LOG   = log2i(WIDTH);
    localparam int BOUND = 2 * LOG + 2;
    localparam int CW    = log2i(BOUND + 2) + 1;

    logic all_spacer, all_valid, any_bad;
    logic clear, load;

    always_comb begin
        all_spacer = 1'b1;
        all_valid  = 1'b1;
        any_bad    = 1'b0;
        for (int i = 0; i < WIDTH; i++) begin
            if (a_dr[2*i +: 2] != DR_NULL || b_dr[2*i +: 2] != DR_NULL)
                all_spacer = 1'b0;
            if (!dr_ok(a_dr[2*i +: 2]) || !dr_ok(b_dr[2*i +: 2]))
                all_valid = 1'b0;
            if (a_dr[2*i +: 2] == DR_BAD || b_dr[2*i +: 2] == DR_BAD)
                any_bad = 1'b1;
        end
    end

    assign clear = rst | all_spacer;
    assign load  = all_valid;

    // heap-ordered tree: node 1 is the root, leaves sit at WIDTH+i
    kgp_e tree [1:2*WIDTH-1];
    dr_t  cin  [0:WIDTH];
    dr_t  cin0_q;

    for (genvar i = 0; i < WIDTH; i++) begin : gen_leaf
        dicla_leaf u_leaf (
            .clk   (clk),
            .clear (clear),
            .load  (load),
            .a_i   (a_dr[2*i +: 2]),
            .b_i   (b_dr[2*i +: 2]),
            .kgp_o (tree[WIDTH+i])
        );
    end

    for (genvar n = 1; n < WIDTH; n++) begin : gen_node
        dicla_node u_node (
            .clk   (clk),
            .clear (clear),
            .hi_i  (tree[2*n+1]),
            .lo_i  (tree[2*n]),
            .grp_o (tree[n])
        );
    end

    always_ff @(posedge clk) begin
        if (clear)
            cin0_q <= DR_NULL;
        else if (load && cin0_q == DR_NULL)
            cin0_q <= DR_ZERO;
    end

    assign cin[0] = cin0_q;

    for (genvar j = 1; j <= WIDTH; j++) begin : gen_carry
        localparam int SPAN = lowbit(j);
        localparam int SIB  = WIDTH / SPAN + (j - SPAN) / SPAN;
        dicla_carry u_carry (
            .clk      (clk),
            .clear    (clear),
            .prev_i   (tree[WIDTH+j-1]),
            .prev_c_i (cin[j-1]),
            .sib_i    (tree[SIB]),
            .base_c_i (cin[j-SPAN]),
            .c_o      (cin[j])
        );
    end

    for (genvar i = 0; i < WIDTH; i++) begin : gen_sum
        dicla_sum u_sum (
            .clk   (clk),
            .clear (clear),
            .bit_i (tree[WIDTH+i]),
            .c_i   (cin[i]),
            .s_o   (sum_dr[2*i +: 2])
        );
    end

    assign cout_dr = cin[WIDTH];

    always_comb begin
        done = dr_ok(cin[WIDTH]);
        for (int i = 0; i < WIDTH; i++)
            if (!dr_ok(sum_dr[2*i +: 2])) done = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) err <= 1'b0;
        else     err <= any_bad;
    end

    // busy-cycle counter used only to bound the latency
    logic [CW-1:0] busy_q;

    always_ff @(posedge clk) begin
        if (clear)
            busy_q <= '0;
        else if (tree[WIDTH] != KGP_NONE && !done)
            busy_q <= busy_q + 1'b1;
    end

    p_latency_bound_r5: assert property (@(posedge clk) disable iff (clear)
        int'(busy_q) < BOUND);

    p_spacer_clears_r7: assert property (@(posedge clk) disable iff (rst)
        all_spacer |=> (!done && cout_dr == DR_NULL));

    p_bad_blocks_r9: assert property (@(posedge clk) disable iff (rst)
        (any_bad && tree[WIDTH] == KGP_NONE) |=> sum_dr[1:0] == DR_NULL);

endmodule

// File: tb/tb_dicla_tree_adder.sv
module tb_dicla_tree_adder;
    localparam int W     = 4;
    localparam int LOGW  = 2;
    localparam int BOUND = 2 * LOGW + 2;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [2*W-1:0] a_dr = '0;
    logic [2*W-1:0] b_dr = '0;
    logic [2*W-1:0] sum_dr;
    logic [1:0]     cout_dr;
    logic           done;
    logic           err;

    int total = 0;
    int bad   = 0;
    bit ended = 1'b0;

    dicla_tree_adder #(.WIDTH(W)) dut (
        .clk     (clk),
        .rst     (rst),
        .a_dr    (a_dr),
        .b_dr    (b_dr),
        .sum_dr  (sum_dr),
        .cout_dr (cout_dr),
        .done    (done),
        .err     (err)
    );

    always #2 clk = ~clk;

    function automatic logic [2*W-1:0] enc(int v);
        logic [2*W-1:0] r;
        for (int i = 0; i < W; i++) r[2*i +: 2] = v[i] ? 2'b10 : 2'b01;
        return r;
    endfunction

    // decoded sum value, -1 when any bit is not a valid code
    function automatic int dec_sum(logic [2*W-1:0] s);
        int r;
        r = 0;
        for (int i = 0; i < W; i++) begin
            if (s[2*i +: 2] == 2'b10) r += (1 << i);
            else if (s[2*i +: 2] != 2'b01) return -1;
        end
        return r;
    endfunction

    function automatic int dec_bit(logic [1:0] c);
        if (c == 2'b10) return 1;
        if (c == 2'b01) return 0;
        return -1;
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    task automatic wait_done(output int lat);
        lat = 0;
        while (!done && lat <= 20) begin
            tick(1);
            lat++;
        end
    endtask

    task automatic run_pair(int a, int b, bit try_hold);
        int lat, s, c, s_hold;
        a_dr = '0;
        b_dr = '0;
        tick(1);
        check(!done && sum_dr == '0 && cout_dr == 2'b00, "R7 spacer",
              int'(sum_dr), 0);
        a_dr = enc(a);
        b_dr = enc(b);
        wait_done(lat);
        s = dec_sum(sum_dr);
        c = dec_bit(cout_dr);
        check(s == ((a + b) % (1 << W)), "R1 R2 sum", s, (a + b) % (1 << W));
        check(c == ((a + b) >> W), "R3 R4 carry-out", c, (a + b) >> W);
        check(lat <= BOUND, "R5 latency bound", lat, BOUND);
        if (a == b)
            check(lat == 3, "R6 short-chain latency", lat, 3);
        if (try_hold) begin
            s_hold = s;
            a_dr = enc((a ^ 5) % (1 << W));
            b_dr = enc((~b) & ((1 << W) - 1));
            tick(3);
            check(done && dec_sum(sum_dr) == s_hold, "R8 held result",
                  dec_sum(sum_dr), s_hold);
        end
    endtask

    initial begin
        int lat;
        logic [2*W-1:0] tmp;
        tick(2);
        check(sum_dr == '0 && cout_dr == 2'b00, "R10 reset sum", int'(sum_dr), 0);
        check(!done && !err, "R10 reset flags", int'({done, err}), 0);
        rst = 1'b0;
        tick(1);

        for (int a = 0; a < (1 << W); a++)
            for (int b = 0; b < (1 << W); b++)
                run_pair(a, b, (a % 3) == 0);

        // illegal code on one bit
        a_dr = '0;
        b_dr = '0;
        tick(1);
        tmp = enc(6);
        tmp[3:2] = 2'b11;
        a_dr = tmp;
        b_dr = enc(3);
        tick(1);
        check(err == 1'b1, "R9 err on illegal", int'(err), 1);
        tick(4);
        check(!done && sum_dr == '0, "R9 no evaluation on illegal", int'(done), 0);
        a_dr = '0;
        b_dr = '0;
        tick(1);
        check(err == 1'b0, "R9 err clears", int'(err), 0);

        // partially presented operand
        a_dr = enc(9);
        tmp = enc(7);
        tmp[5:4] = 2'b00;
        b_dr = tmp;
        tick(5);
        check(!done && sum_dr == '0, "R9 waits for full operand", int'(done), 0);
        b_dr = enc(7);
        wait_done(lat);
        check(dec_sum(sum_dr) == 0 && dec_bit(cout_dr) == 1, "R9 resumes",
              dec_sum(sum_dr), 0);

        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        finish_run();
    end

endmodule